// File: doc/BRIEF.md
# Banked Multi-Read Memory Array

This block holds a logical array of `DEPTH` words spread over `BANKS` physical banks, so that one write and several reads can be served in the same clock cycle. Every port addresses the array by its logical index. The block turns that index into a bank number and a row inside the bank. A parameter picks one of two mappings. The first places runs of consecutive indices in one bank. The second deals consecutive indices out to the banks in turn.

Each bank can serve two accesses per cycle. The write comes first, then the reads in ascending port number. A request that finds its bank already full is dropped, and the block raises a conflict flag in that cycle. An index at or beyond `DEPTH` is dropped and raises an out-of-range flag. When `BANKS` equals `DEPTH`, every element becomes its own register and the two-access limit no longer applies. Reads are synchronous and return data one cycle after the request.

Top module: `pbank_array`

## Requirements
- R1: With the block mapping, let S = ceil(DEPTH/BANKS). Index i lives in bank i/S at row i mod S, and the last used bank holds the remaining DEPTH−(k·S) words when DEPTH is not a multiple of BANKS. Every read of an in-range index returns the value last written to that index.
- R2: With the cyclic mapping, index i lives in bank i mod BANKS at row i/BANKS. Every read of an in-range index returns the value last written to that index.
- R3: A read that is accepted in cycle t shows `rd_ok`=1 and its data on `rd_data` in cycle t+1. In any cycle where a port's `rd_ok` is 0, that port's `rd_data` is all zeros.
- R4: When a read and a write target the same index in one cycle, the read returns the old value. A read issued in the following cycle returns the new value.
- R5: A bank accepts at most two accesses per cycle. The write has first claim, then the reads in ascending port number. A read beyond the limit is dropped (`rd_ok`=0 in the next cycle), and `conflict` is 1 in the cycle of the request.
- R6: When BANKS equals DEPTH, there is no per-bank limit. Any mix of in-range requests is accepted, and `conflict` stays 0.
- R7: A request whose index is DEPTH or larger has no effect. A write leaves the array unchanged, and a read gives `rd_ok`=0 in the next cycle. The request uses no bank slot, and `out_of_range` is 1 in the cycle of the request.
- R8: After reset, with no requests, `rd_ok` is all zeros and both `conflict` and `out_of_range` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Logical write index |
| wr_data | input | WIDTH | Write data |
| rd_en | input | RD_PORTS | Read request, one bit per port |
| rd_idx | input | RD_PORTS*IDX_W | Logical read indices, port r at bits [r*IDX_W +: IDX_W] |
| rd_ok | output | RD_PORTS | Read accepted in the previous cycle, one bit per port |
| rd_data | output | RD_PORTS*WIDTH | Read data, port r at bits [r*WIDTH +: WIDTH] |
| conflict | output | 1 | An in-range request was dropped by a full bank in this cycle |
| out_of_range | output | 1 | A request in this cycle carries an index of DEPTH or larger |

## Verification
A wrong index-to-bank or index-to-row mapping, or a write that goes astray, returns a stale or foreign word. This shows on `rd_data` one cycle after the first read of an affected index. Per-cycle arbitration errors show at once on `conflict`, or one cycle later as a wrong `rd_ok` bit. The bench keeps a flat reference array and recounts the bank load of every cycle on its own. It checks four configurations: block mapping with an uneven depth, cyclic mapping with uneven and even depths, and full partitioning.

// File: rtl/pbank_pkg.sv
package pbank_pkg;

  typedef enum logic {MAP_BLOCK = 1'b0, MAP_CYCLIC = 1'b1} map_e;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // rows physically needed by bank b (never below one)
  function automatic int bank_rows(input int depth, input int banks, input map_e mode, input int b);
    int n;
    if (mode == MAP_BLOCK) begin
      n = depth - b * ceil_div(depth, banks);
      if (n > ceil_div(depth, banks)) n = ceil_div(depth, banks);
    end else begin
      n = ceil_div(depth - b, banks);
    end
    if (n < 1) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/pbank_map.sv
module pbank_map #(
  parameter int            DEPTH  = 10,
  parameter int            BANKS  = 4,
  parameter pbank_pkg::map_e MAP  = pbank_pkg::MAP_BLOCK,
  parameter int            IDX_W  = 5,
  parameter int            BANK_W = 2,
  parameter int            OFF_W  = 2
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [BANK_W-1:0] bank,
  output logic [OFF_W-1:0]  off,
  output logic              in_range
);
  localparam int SPAN = pbank_pkg::ceil_div(DEPTH, BANKS);

  assign in_range = (int'(idx) < DEPTH);

  generate
    if (MAP == pbank_pkg::MAP_BLOCK) begin : g_block
      always_comb begin
        bank = BANK_W'(int'(idx) / SPAN);
        off  = OFF_W'(int'(idx) % SPAN);
      end
    end else begin : g_cyclic
      always_comb begin
        bank = BANK_W'(int'(idx) % BANKS);
        off  = OFF_W'(int'(idx) / BANKS);
      end
    end
  endgenerate

endmodule

// File: rtl/pbank_arb.sv
module pbank_arb #(
  parameter int NA     = 4,
  parameter int LIMIT  = 2,
  parameter int BANK_W = 2,
  parameter int SLOT_W = 1
) (
  input  logic [NA-1:0]             valid,
  input  logic [NA-1:0][BANK_W-1:0] bank,
  output logic [NA-1:0]             grant,
  output logic [NA-1:0][SLOT_W-1:0] slot
);
  // access 0 has top priority; a request's slot is the number of
  // earlier valid requests aimed at the same bank
  always_comb begin
    for (int a = 0; a < NA; a++) begin
      int cnt;
      cnt = 0;
      for (int j = 0; j < a; j++) begin
        if (valid[j] && bank[j] == bank[a]) cnt++;
      end
      grant[a] = valid[a] && (cnt < LIMIT);
      slot[a]  = (cnt < LIMIT) ? SLOT_W'(cnt) : '0;
    end
  end

endmodule

// File: rtl/pbank_store.sv
module pbank_store #(
  parameter int WIDTH = 16,
  parameter int ROWS  = 3,
  parameter int NP    = 2,
  parameter int AW    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NP-1:0]          en,
  input  logic [NP-1:0]          we,
  input  logic [NP-1:0][AW-1:0]  addr,
  input  logic [WIDTH-1:0]       wdata,
  output logic [NP-1:0][WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [ROWS];
  logic [NP-1:0][WIDTH-1:0] rdata_q;

  always_ff @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (en[p] && we[p] && int'(addr[p]) < ROWS) mem[addr[p]] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (en[p] && !we[p] && int'(addr[p]) < ROWS) rdata_q[p] <= mem[addr[p]];
    end
  end

  assign rdata = rdata_q;

  a_r5_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en & we));

endmodule

// File: rtl/pbank_array.sv
module pbank_array #(
  parameter int              DEPTH    = 10,
  parameter int              BANKS    = 4,
  parameter pbank_pkg::map_e MAP      = pbank_pkg::MAP_BLOCK,
  parameter int              WIDTH    = 16,
  parameter int              RD_PORTS = 3,
  parameter int              IDX_W    = $clog2(DEPTH) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [WIDTH-1:0]          wr_data,
  input  logic [RD_PORTS-1:0]       rd_en,
  input  logic [RD_PORTS*IDX_W-1:0] rd_idx,
  output logic [RD_PORTS-1:0]       rd_ok,
  output logic [RD_PORTS*WIDTH-1:0] rd_data,
  output logic                      conflict,
  output logic                      out_of_range
);
  localparam int NA     = RD_PORTS + 1;
  localparam int SPAN   = pbank_pkg::ceil_div(DEPTH, BANKS);
  localparam int LIMIT  = (BANKS == DEPTH) ? NA : 2;
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam int OFF_W  = (SPAN > 1) ? $clog2(SPAN) : 1;
  localparam int SLOT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [NA-1:0][IDX_W-1:0]  acc_idx;
  logic [NA-1:0]             acc_req, acc_in, acc_valid, grant;
  logic [NA-1:0][BANK_W-1:0] acc_bank;
  logic [NA-1:0][OFF_W-1:0]  acc_off;
  logic [NA-1:0][SLOT_W-1:0] acc_slot;

  assign acc_idx[0] = wr_idx;
  assign acc_req[0] = wr_en;

  genvar gr, ga, gb;
  generate
    for (gr = 0; gr < RD_PORTS; gr++) begin : g_rd_in
      assign acc_idx[gr+1] = rd_idx[gr*IDX_W +: IDX_W];
      assign acc_req[gr+1] = rd_en[gr];
    end
    for (ga = 0; ga < NA; ga++) begin : g_map
      pbank_map #(
        .DEPTH(DEPTH), .BANKS(BANKS), .MAP(MAP),
        .IDX_W(IDX_W), .BANK_W(BANK_W), .OFF_W(OFF_W)
      ) u_map (
        .idx(acc_idx[ga]), .bank(acc_bank[ga]),
        .off(acc_off[ga]), .in_range(acc_in[ga])
      );
    end
  endgenerate

  assign acc_valid = acc_req & acc_in;

  pbank_arb #(.NA(NA), .LIMIT(LIMIT), .BANK_W(BANK_W), .SLOT_W(SLOT_W)) u_arb (
    .valid(acc_valid), .bank(acc_bank), .grant(grant), .slot(acc_slot)
  );

  assign conflict     = |(acc_valid & ~grant);
  assign out_of_range = |(acc_req & ~acc_in);

  // route granted accesses onto bank slots
  logic [BANKS-1:0][LIMIT-1:0]             bk_en, bk_we;
  logic [BANKS-1:0][LIMIT-1:0][OFF_W-1:0]  bk_addr;
  logic [BANKS-1:0][LIMIT-1:0][WIDTH-1:0]  bk_rd;

  always_comb begin
    bk_en   = '0;
    bk_we   = '0;
    bk_addr = '0;
    for (int b = 0; b < BANKS; b++) begin
      for (int s = 0; s < LIMIT; s++) begin
        for (int a = 0; a < NA; a++) begin
          if (grant[a] && acc_bank[a] == BANK_W'(b) && acc_slot[a] == SLOT_W'(s)) begin
            bk_en[b][s]   = 1'b1;
            bk_we[b][s]   = (a == 0);
            bk_addr[b][s] = acc_off[a];
          end
        end
      end
    end
  end

  generate
    for (gb = 0; gb < BANKS; gb++) begin : g_bank
      pbank_store #(
        .WIDTH(WIDTH), .ROWS(pbank_pkg::bank_rows(DEPTH, BANKS, MAP, gb)),
        .NP(LIMIT), .AW(OFF_W)
      ) u_store (
        .clk(clk), .rst_n(rst_n), .en(bk_en[gb]), .we(bk_we[gb]),
        .addr(bk_addr[gb]), .wdata(wr_data), .rdata(bk_rd[gb])
      );
    end
  endgenerate

  // read return path: next-state then registers
  logic [RD_PORTS-1:0]             ok_d, ok_q;
  logic [RD_PORTS-1:0][BANK_W-1:0] sel_bank_q;
  logic [RD_PORTS-1:0][SLOT_W-1:0] sel_slot_q;

  always_comb ok_d = grant[NA-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= '0;
    else        ok_q <= ok_d;
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < RD_PORTS; r++) begin
      if (ok_d[r]) begin
        sel_bank_q[r] <= acc_bank[r+1];
        sel_slot_q[r] <= acc_slot[r+1];
      end
    end
  end

  always_comb begin
    for (int r = 0; r < RD_PORTS; r++) begin
      rd_data[r*WIDTH +: WIDTH] = ok_q[r] ? bk_rd[sel_bank_q[r]][sel_slot_q[r]] : '0;
    end
  end

  assign rd_ok = ok_q;

  generate
    for (gr = 0; gr < RD_PORTS; gr++) begin : g_chk
      a_r3_ok_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok[gr] |-> $past(rd_en[gr]));
      a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok[gr] |-> (rd_data[gr*WIDTH +: WIDTH] == '0));
      a_r7_far_read_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en[gr] && rd_idx[gr*IDX_W +: IDX_W] >= IDX_W'(DEPTH)) |=> !rd_ok[gr]);
      a_r5_calm_read_served: assert property (@(posedge clk) disable iff (!rst_n)
        (!conflict && rd_en[gr] && rd_idx[gr*IDX_W +: IDX_W] < IDX_W'(DEPTH)) |=> rd_ok[gr]);
    end
  endgenerate

  a_r5_write_first: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid[0] |-> grant[0]);

endmodule

// File: tb/pbank_array_bench.sv
module pbank_env #(
  parameter int              N   = 10,
  parameter int              F   = 4,
  parameter pbank_pkg::map_e MV  = pbank_pkg::MAP_BLOCK,
  parameter int              RP  = 3,
  parameter int              W   = 16,
  parameter int              NRAND = 300
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int IW  = $clog2(N) + 1;
  localparam int LIM = (F == N) ? RP + 1 : 2;
  localparam int SP  = (N + F - 1) / F;

  logic              wr_en;
  logic [IW-1:0]     wr_idx;
  logic [W-1:0]      wr_data;
  logic [RP-1:0]     rd_en;
  logic [RP*IW-1:0]  rd_idx;
  logic [RP-1:0]     rd_ok;
  logic [RP*W-1:0]   rd_data;
  logic              conflict, out_of_range;

  pbank_array #(.DEPTH(N), .BANKS(F), .MAP(MV), .WIDTH(W), .RD_PORTS(RP), .IDX_W(IW)) u_pbank_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_ok(rd_ok), .rd_data(rd_data),
    .conflict(conflict), .out_of_range(out_of_range)
  );

  int n_chk = 0;
  int n_err = 0;
  int refm [N];
  logic [RP-1:0] exp_ok;
  int exp_dat [RP];
  bit r4_mark [RP];

  logic          s_wen;
  int            s_widx;
  int            s_wdat;
  logic [RP-1:0] s_ren;
  int            s_ridx [RP];
  bit            s_r4;

  string maptag;
  initial maptag = (MV == pbank_pkg::MAP_BLOCK) ? "R1" : "R2";

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s cfg N=%0d F=%0d: actual=%0d expected=%0d", tag, N, F, act, expv);
    end
  endtask

  function automatic int bank_of(input int i);
    return (MV == pbank_pkg::MAP_BLOCK) ? i / SP : i % F;
  endfunction

  task automatic cycle();
    int cnt [F];
    bit e_conf, e_oor;
    @(negedge clk);
    for (int r = 0; r < RP; r++) begin
      chk(rd_ok[r] == exp_ok[r], "R5 rd_ok", int'(rd_ok[r]), int'(exp_ok[r]));
      if (exp_ok[r])
        chk(int'(rd_data[r*W +: W]) == exp_dat[r], r4_mark[r] ? "R4" : maptag,
            int'(rd_data[r*W +: W]), exp_dat[r]);
      else
        chk(rd_data[r*W +: W] == '0, "R3 idle data", int'(rd_data[r*W +: W]), 0);
    end
    wr_en   = s_wen;
    wr_idx  = IW'(s_widx);
    wr_data = W'(s_wdat);
    rd_en   = s_ren;
    for (int r = 0; r < RP; r++) rd_idx[r*IW +: IW] = IW'(s_ridx[r]);
    #1;
    foreach (cnt[b]) cnt[b] = 0;
    e_conf = 0; e_oor = 0;
    if (s_wen) begin
      if (s_widx >= N) e_oor = 1;
      else cnt[bank_of(s_widx)]++;
    end
    for (int r = 0; r < RP; r++) begin
      exp_ok[r] = 0; exp_dat[r] = 0; r4_mark[r] = s_r4;
      if (s_ren[r]) begin
        if (s_ridx[r] >= N) e_oor = 1;
        else begin
          if (cnt[bank_of(s_ridx[r])] < LIM) begin
            exp_ok[r] = 1; exp_dat[r] = refm[s_ridx[r]];
          end else e_conf = 1;
          cnt[bank_of(s_ridx[r])]++;
        end
      end
    end
    chk(conflict == e_conf, (F == N) ? "R6 conflict" : "R5 conflict", int'(conflict), int'(e_conf));
    chk(out_of_range == e_oor, "R7 out_of_range", int'(out_of_range), int'(e_oor));
    if (s_wen && s_widx < N) refm[s_widx] = s_wdat & ((1 << W) - 1);
  endtask

  initial begin
    done = 0;
    wr_en = 0; wr_idx = '0; wr_data = '0; rd_en = '0; rd_idx = '0;
    exp_ok = '0;
    s_wen = 0; s_widx = 0; s_wdat = 0; s_ren = '0; s_r4 = 0;
    for (int r = 0; r < RP; r++) begin s_ridx[r] = 0; exp_dat[r] = 0; r4_mark[r] = 0; end
    @(posedge rst_n);
    @(negedge clk);
    // R8: idle state after reset
    chk(rd_ok == '0, "R8 rd_ok", int'(rd_ok), 0);
    chk(!conflict, "R8 conflict", int'(conflict), 0);
    chk(!out_of_range, "R8 out_of_range", int'(out_of_range), 0);
    // fill every element
    for (int i = 0; i < N; i++) begin
      s_wen = 1; s_widx = i; s_wdat = int'($urandom_range(0, 65535)); s_ren = '0;
      cycle();
    end
    // R7: far write must not disturb anything; far reads dropped
    s_wen = 1; s_widx = N; s_wdat = 16'h1234; s_ren = '1;
    for (int r = 0; r < RP; r++) s_ridx[r] = N + r;
    cycle();
    // R4: read and write of the same index in one cycle
    s_r4 = 1; s_wen = 1; s_widx = N - 1; s_wdat = 16'hBEEF; s_ren = 'b1; s_ridx[0] = N - 1;
    cycle();
    s_wen = 0; s_ren = 'b1;
    cycle();
    s_r4 = 0;
    // R5/R6: every port aims at one bank together with the write
    s_wen = 1; s_widx = 0; s_wdat = 16'h0A0A; s_ren = '1;
    for (int r = 0; r < RP; r++) s_ridx[r] = 0;
    cycle();
    s_wen = 0;
    for (int r = 0; r < RP; r++) s_ridx[r] = (MV == pbank_pkg::MAP_BLOCK) ? (r % SP) : (r * F) % N;
    cycle();
    // mixed random traffic
    for (int k = 0; k < NRAND; k++) begin
      s_wen  = ($urandom_range(0, 1) == 1);
      s_widx = int'($urandom_range(0, N));
      s_wdat = int'($urandom_range(0, 65535));
      s_ren  = RP'($urandom_range(0, (1 << RP) - 1));
      for (int r = 0; r < RP; r++) s_ridx[r] = int'($urandom_range(0, N + 1));
      cycle();
    end
    s_wen = 0; s_ren = '0;
    cycle();
    cycle();
    done = 1;
  end

endmodule

module pbank_array_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic d_blk, d_cyc, d_even, d_full;

  pbank_env #(.N(10), .F(4), .MV(pbank_pkg::MAP_BLOCK))  e_blk  (.clk(clk), .rst_n(rst_n), .done(d_blk));
  pbank_env #(.N(10), .F(4), .MV(pbank_pkg::MAP_CYCLIC)) e_cyc  (.clk(clk), .rst_n(rst_n), .done(d_cyc));
  pbank_env #(.N(8),  .F(4), .MV(pbank_pkg::MAP_CYCLIC)) e_even (.clk(clk), .rst_n(rst_n), .done(d_even));
  pbank_env #(.N(4),  .F(4), .MV(pbank_pkg::MAP_BLOCK))  e_full (.clk(clk), .rst_n(rst_n), .done(d_full));

  int cyc = 0;
  bit wd_hit = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) wd_hit <= 1;
  end

  initial begin
    int errs, tot;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    wait ((d_blk && d_cyc && d_even && d_full) || wd_hit);
    errs = e_blk.n_err + e_cyc.n_err + e_even.n_err + e_full.n_err;
    tot  = e_blk.n_chk + e_cyc.n_chk + e_even.n_chk + e_full.n_chk;
    if (wd_hit) begin
      errs++; tot++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
    end
    $display("Result: errors=%0d of %0d checks", errs, tot);
    $finish;
  end
endmodule